// File: doc/BRIEF.md
# Low-Power Mode Sequencing Controller

This block steps a small microcontroller between its full-speed state and a set of reduced-power states. Software raises single-cycle entry requests. Wake sources are an interrupt, an event, a real-time-clock wake and an external interrupt. From these the controller decides which clocks run, whether the program and data memories are powered down, and whether the voltage regulator is in main or low-power mode. It does not model oscillators or the regulator. A main-oscillator ready input gates the return from low-speed run. A wake-delay counter stands in for settling after the two halt states.

The states are:
- Run (`M_RUN`): everything is clocked.
- Wait (`M_WAIT`): the CPU clock is stopped. Selected peripherals keep their clocks.
- Low-speed run (`M_LSRUN`): the CPU runs, the memories are off and the regulator is in low-power mode.
- Low-speed wait (`M_LSWAIT`): as low-speed run, with the CPU clock stopped.
- Active-halt (`M_AHALT`): only the real-time-clock clock runs.
- Halt (`M_HALT`): all clocks are off.
- Wake (`M_WAKE`): a transient settling state between either halt state and run.

The transitions are:
- Run to Halt, Active-halt, Low-speed run or Wait, on the matching request.
- Wait to Run, on an interrupt or event.
- Low-speed run to Low-speed wait, on wait-for-event.
- Low-speed run to Run, on an exit request once the oscillator is ready.
- Low-speed wait to Low-speed run, on an event.
- Active-halt to Wake, on a real-time-clock wake or external interrupt.
- Halt to Wake, on an external interrupt.
- Wake to Run, when the delay expires.
- Any state to Run, on reset.

Top module: `lpm_ctrl`

## Requirements
- R1: An active-low `rst_n` puts the controller in run (mode code 0) without waiting for a clock edge, and drops any pending low-speed exit request; after release the outputs read cpu_clk_en=1, all peripheral enables 1, rtc_clk_en=1, mem_pd=0, reg_lp=0.
- R2: In run, requests are served one edge later with priority halt (mode 5) over active-halt (mode 4) over low-speed entry (mode 2) over wait-for-interrupt or wait-for-event (mode 1); with no request run is held.
- R3: Wait (mode 1) stops only the CPU clock, drives each peripheral enable from its `periph_keep` bit, and returns to run on the edge after `irq` or `evt`.
- R4: Low-speed run (mode 2) ignores `irq` and all requests except wait-for-event and exit. An exit request stays pending until `hs_ready` is high, then moves to run on that edge; a pending exit has priority over wait-for-event.
- R5: Wait-for-event in low-speed run enters low-speed wait (mode 3), which stops the CPU clock and masks peripherals by `periph_keep`. Only `evt` leaves it, and it returns to low-speed run, not to run.
- R6: Active-halt (mode 4) keeps only rtc_clk_en on. `rtc_wake` or `ext_irq` moves it to wake (mode 6); `irq` and `evt` have no effect.
- R7: Halt (mode 5) turns every clock enable off. Only `ext_irq` moves it to wake; `rtc_wake`, `irq` and `evt` have no effect.
- R8: Wake (mode 6) lasts exactly FAST_WAKE cycles if `fast_wake` was high on the wake edge, else SLOW_WAKE cycles, with CPU and peripheral clocks off; then run follows.
- R9: reg_lp is 1 in modes 2, 3, 4 and 5 and 0 in modes 0, 1 and 6; mem_pd is 1 only in modes 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_wfi | input | 1 | Wait-for-interrupt request pulse |
| req_wfe | input | 1 | Wait-for-event request pulse |
| req_ls_enter | input | 1 | Low-speed run entry request |
| req_ls_exit | input | 1 | Low-speed run exit request |
| req_halt | input | 1 | Halt entry request |
| req_ahalt | input | 1 | Active-halt entry request |
| irq | input | 1 | Interrupt wake |
| evt | input | 1 | Peripheral or I/O event |
| rtc_wake | input | 1 | Real-time-clock wake |
| ext_irq | input | 1 | External interrupt |
| fast_wake | input | 1 | Selects the short wake delay |
| hs_ready | input | 1 | Main oscillator ready |
| periph_keep | input | NPERIPH | Peripherals kept clocked in the wait states |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | NPERIPH | Peripheral clock enables |
| rtc_clk_en | output | 1 | Real-time-clock clock enable |
| mem_pd | output | 1 | Program and data memory power-down |
| reg_lp | output | 1 | Regulator low-power mode select |
| mode_o | output | 3 | Current mode code |

## Verification
The bench builds the controller with SLOW_WAKE=20 and FAST_WAKE=3, and keeps NPERIPH at 8. The short settling counts let a random run pass through many halt-to-wake-to-run cycles, so both delay lengths are measured many times within the cycle budget. The eight-bit `periph_keep` mask is randomised, so the two wait states are seen with many different peripheral selections.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
    typedef enum logic [2:0] {
        M_RUN    = 3'd0,
        M_WAIT   = 3'd1,
        M_LSRUN  = 3'd2,
        M_LSWAIT = 3'd3,
        M_AHALT  = 3'd4,
        M_HALT   = 3'd5,
        M_WAKE   = 3'd6
    } lpm_mode_e;
endpackage

// File: rtl/lpm_exit_latch.sv
// Holds a low-speed exit request until the main oscillator reports ready.
module lpm_exit_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic in_lsrun,
    input  logic req_exit,
    input  logic hs_ready,
    output logic pend_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else begin
            pend_q <= in_lsrun & (pend_q | req_exit) & ~hs_ready;
        end
    end
endmodule

// File: rtl/lpm_wake_timer.sv
// Settling counter run between a halt state and run.
module lpm_wake_timer #(
    parameter int SLOW_WAKE = 40,
    parameter int FAST_WAKE = 4,
    localparam int CNT_W = $clog2(SLOW_WAKE + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic fast,
    input  logic in_wake,
    output logic done
);
    localparam logic [CNT_W-1:0] SLOW_LD = CNT_W'(SLOW_WAKE - 1);
    localparam logic [CNT_W-1:0] FAST_LD = CNT_W'(FAST_WAKE - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= fast ? FAST_LD : SLOW_LD;
        end else if (in_wake && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = in_wake && (cnt_q == '0);
endmodule

// File: rtl/lpm_fsm.sv
// Mode state machine with state-decoded clock, memory and regulator outputs.
module lpm_fsm
    import lpm_pkg::*;
#(
    parameter int NPERIPH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_wfi,
    input  logic               req_wfe,
    input  logic               req_ls_enter,
    input  logic               req_ls_exit,
    input  logic               req_halt,
    input  logic               req_ahalt,
    input  logic               irq,
    input  logic               evt,
    input  logic               rtc_wake,
    input  logic               ext_irq,
    input  logic               hs_ready,
    input  logic               pend_q,
    input  logic               wake_done,
    input  logic [NPERIPH-1:0] periph_keep,
    output lpm_mode_e          mode,
    output logic               wake_load,
    output logic               cpu_clk_en,
    output logic [NPERIPH-1:0] periph_clk_en,
    output logic               rtc_clk_en,
    output logic               mem_pd,
    output logic               reg_lp
);
    lpm_mode_e mode_d;
    logic      exit_want;

    assign exit_want = pend_q | req_ls_exit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode <= M_RUN;
        end else begin
            mode <= mode_d;
        end
    end

    always_comb begin
        mode_d    = mode;
        wake_load = 1'b0;
        unique case (mode)
            M_RUN: begin
                if (req_halt)                mode_d = M_HALT;
                else if (req_ahalt)          mode_d = M_AHALT;
                else if (req_ls_enter)       mode_d = M_LSRUN;
                else if (req_wfi || req_wfe) mode_d = M_WAIT;
            end
            M_WAIT: begin
                if (irq || evt) mode_d = M_RUN;
            end
            M_LSRUN: begin
                if (exit_want) begin
                    if (hs_ready) mode_d = M_RUN;
                end else if (req_wfe) begin
                    mode_d = M_LSWAIT;
                end
            end
            M_LSWAIT: begin
                if (evt) mode_d = M_LSRUN;
            end
            M_AHALT: begin
                if (rtc_wake || ext_irq) begin
                    mode_d    = M_WAKE;
                    wake_load = 1'b1;
                end
            end
            M_HALT: begin
                if (ext_irq) begin
                    mode_d    = M_WAKE;
                    wake_load = 1'b1;
                end
            end
            M_WAKE: begin
                if (wake_done) mode_d = M_RUN;
            end
            default: mode_d = M_RUN;
        endcase
    end

    always_comb begin
        cpu_clk_en    = 1'b0;
        periph_clk_en = '0;
        rtc_clk_en    = 1'b1;
        mem_pd        = 1'b0;
        reg_lp        = 1'b0;
        unique case (mode)
            M_RUN: begin
                cpu_clk_en    = 1'b1;
                periph_clk_en = '1;
            end
            M_WAIT: begin
                periph_clk_en = periph_keep;
            end
            M_LSRUN: begin
                cpu_clk_en    = 1'b1;
                periph_clk_en = '1;
                mem_pd        = 1'b1;
                reg_lp        = 1'b1;
            end
            M_LSWAIT: begin
                periph_clk_en = periph_keep;
                mem_pd        = 1'b1;
                reg_lp        = 1'b1;
            end
            M_AHALT: begin
                reg_lp = 1'b1;
            end
            M_HALT: begin
                rtc_clk_en = 1'b0;
                reg_lp     = 1'b1;
            end
            M_WAKE: begin
                rtc_clk_en = 1'b1;
            end
            default: begin
                cpu_clk_en = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
    import lpm_pkg::*;
#(
    parameter int NPERIPH   = 8,
    parameter int SLOW_WAKE = 40,
    parameter int FAST_WAKE = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_wfi,
    input  logic               req_wfe,
    input  logic               req_ls_enter,
    input  logic               req_ls_exit,
    input  logic               req_halt,
    input  logic               req_ahalt,
    input  logic               irq,
    input  logic               evt,
    input  logic               rtc_wake,
    input  logic               ext_irq,
    input  logic               fast_wake,
    input  logic               hs_ready,
    input  logic [NPERIPH-1:0] periph_keep,
    output logic               cpu_clk_en,
    output logic [NPERIPH-1:0] periph_clk_en,
    output logic               rtc_clk_en,
    output logic               mem_pd,
    output logic               reg_lp,
    output logic [2:0]         mode_o
);
    lpm_mode_e mode;
    logic      pend_q;
    logic      wake_load;
    logic      wake_done;

    lpm_exit_latch u_exit (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_lsrun (mode == M_LSRUN),
        .req_exit (req_ls_exit),
        .hs_ready (hs_ready),
        .pend_q   (pend_q)
    );

    lpm_wake_timer #(
        .SLOW_WAKE (SLOW_WAKE),
        .FAST_WAKE (FAST_WAKE)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (wake_load),
        .fast    (fast_wake),
        .in_wake (mode == M_WAKE),
        .done    (wake_done)
    );

    lpm_fsm #(
        .NPERIPH (NPERIPH)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_wfi       (req_wfi),
        .req_wfe       (req_wfe),
        .req_ls_enter  (req_ls_enter),
        .req_ls_exit   (req_ls_exit),
        .req_halt      (req_halt),
        .req_ahalt     (req_ahalt),
        .irq           (irq),
        .evt           (evt),
        .rtc_wake      (rtc_wake),
        .ext_irq       (ext_irq),
        .hs_ready      (hs_ready),
        .pend_q        (pend_q),
        .wake_done     (wake_done),
        .periph_keep   (periph_keep),
        .mode          (mode),
        .wake_load     (wake_load),
        .cpu_clk_en    (cpu_clk_en),
        .periph_clk_en (periph_clk_en),
        .rtc_clk_en    (rtc_clk_en),
        .mem_pd        (mem_pd),
        .reg_lp        (reg_lp)
    );

    assign mode_o = mode;
endmodule

// File: rtl/lpm_checker.sv
module lpm_checker #(
    parameter int NPERIPH   = 8,
    parameter int SLOW_WAKE = 40
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_wfe,
    input logic               req_ls_exit,
    input logic               irq,
    input logic               evt,
    input logic               rtc_wake,
    input logic               ext_irq,
    input logic               hs_ready,
    input logic               cpu_clk_en,
    input logic [NPERIPH-1:0] periph_clk_en,
    input logic               rtc_clk_en,
    input logic [2:0]         mode_o
);
    localparam int WC_W = $clog2(SLOW_WAKE + 2);

    logic [WC_W-1:0] wake_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wake_run <= '0;
        end else if (mode_o == 3'd6) begin
            wake_run <= wake_run + 1'b1;
        end else begin
            wake_run <= '0;
        end
    end

    a_r3_wait_wakes: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd1 && (irq || evt)) |=> (mode_o == 3'd0));

    a_r4_lsrun_holds_unready: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd2 && !hs_ready && !req_wfe) |=> (mode_o == 3'd2));

    a_r5_lswait_event: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd3 && evt) |=> (mode_o == 3'd2));

    a_r5_lswait_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd3 && !evt) |=> (mode_o == 3'd3));

    a_r6_ahalt_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd4 && (rtc_wake || ext_irq)) |=> (mode_o == 3'd6));

    a_r7_halt_ext_only: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd5 && !ext_irq) |=> (mode_o == 3'd5 && !rtc_clk_en));

    a_r8_wake_clocks_off: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd6) |-> (!cpu_clk_en && periph_clk_en == '0));

    a_r8_wake_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd6) |-> (int'(wake_run) < SLOW_WAKE));

    a_r4_exit_only_via_run: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd2 && req_ls_exit && hs_ready) |=> (mode_o == 3'd0));
endmodule

bind lpm_ctrl lpm_checker #(
    .NPERIPH   (NPERIPH),
    .SLOW_WAKE (SLOW_WAKE)
) u_lpm_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_wfe       (req_wfe),
    .req_ls_exit   (req_ls_exit),
    .irq           (irq),
    .evt           (evt),
    .rtc_wake      (rtc_wake),
    .ext_irq       (ext_irq),
    .hs_ready      (hs_ready),
    .cpu_clk_en    (cpu_clk_en),
    .periph_clk_en (periph_clk_en),
    .rtc_clk_en    (rtc_clk_en),
    .mode_o        (mode_o)
);

// File: tb/test_lpm_ctrl.sv
`timescale 1ns/1ps
module test_lpm_ctrl;
    localparam int NP   = 8;
    localparam int SLOW = 20;
    localparam int FAST = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_wfi = 0, req_wfe = 0, req_ls_enter = 0, req_ls_exit = 0;
    logic req_halt = 0, req_ahalt = 0, irq = 0, evt = 0, rtc_wake = 0;
    logic ext_irq = 0, fast_wake = 0, hs_ready = 0;
    logic [NP-1:0] periph_keep = '0;
    logic cpu_clk_en, rtc_clk_en, mem_pd, reg_lp;
    logic [NP-1:0] periph_clk_en;
    logic [2:0] mode_o;

    int checks = 0;
    int failures = 0;

    // reference model state
    int m_mode = 0;
    bit m_pend = 0;
    int m_cnt = 0;

    always #2 clk = ~clk;

    lpm_ctrl #(.NPERIPH(NP), .SLOW_WAKE(SLOW), .FAST_WAKE(FAST)) i_lpm_ctrl (
        .clk(clk), .rst_n(rst_n), .req_wfi(req_wfi), .req_wfe(req_wfe),
        .req_ls_enter(req_ls_enter), .req_ls_exit(req_ls_exit),
        .req_halt(req_halt), .req_ahalt(req_ahalt), .irq(irq), .evt(evt),
        .rtc_wake(rtc_wake), .ext_irq(ext_irq), .fast_wake(fast_wake),
        .hs_ready(hs_ready), .periph_keep(periph_keep),
        .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en),
        .rtc_clk_en(rtc_clk_en), .mem_pd(mem_pd), .reg_lp(reg_lp),
        .mode_o(mode_o));

    function automatic string tag_of(int m);
        case (m)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3: return "R5";
            4: return "R6";
            5: return "R7";
            default: return "R8";
        endcase
    endfunction

    // expected {cpu, periph, rtc, mem_pd, reg_lp} from the requirement tables
    function automatic logic [NP+3:0] exp_outs(int m, logic [NP-1:0] keep);
        logic cpu, rtc, mpd, rlp;
        logic [NP-1:0] per;
        cpu = (m == 0 || m == 2);
        per = (m == 0 || m == 2) ? '1 : (m == 1 || m == 3) ? keep : '0;
        rtc = (m != 5);
        mpd = (m == 2 || m == 3);
        rlp = (m >= 2 && m <= 5);
        return {cpu, per, rtc, mpd, rlp};
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        logic [NP+3:0] e;
        e = exp_outs(m_mode, periph_keep);
        check(tag_of(m_mode), 32'(mode_o), 32'(m_mode));
        check(tag_of(m_mode), 32'({cpu_clk_en, periph_clk_en, rtc_clk_en}),
              32'(e[NP+3:2]));
        check("R9", 32'({mem_pd, reg_lp}), 32'(e[1:0]));
    endtask

    task automatic model_step();
        bit ex;
        case (m_mode)
            0: begin
                if (req_halt) m_mode = 5;
                else if (req_ahalt) m_mode = 4;
                else if (req_ls_enter) m_mode = 2;
                else if (req_wfi || req_wfe) m_mode = 1;
            end
            1: if (irq || evt) m_mode = 0;
            2: begin
                ex = m_pend || req_ls_exit;
                m_pend = ex && !hs_ready;
                if (ex && hs_ready) m_mode = 0;
                else if (!ex && req_wfe) m_mode = 3;
            end
            3: if (evt) m_mode = 2;
            4: if (rtc_wake || ext_irq) begin m_mode = 6; m_cnt = fast_wake ? FAST : SLOW; end
            5: if (ext_irq) begin m_mode = 6; m_cnt = fast_wake ? FAST : SLOW; end
            default: begin
                m_cnt--;
                if (m_cnt == 0) m_mode = 0;
            end
        endcase
        if (m_mode != 2) m_pend = 0;
    endtask

    task automatic clear_in();
        {req_wfi, req_wfe, req_ls_enter, req_ls_exit, req_halt, req_ahalt} = '0;
        {irq, evt, rtc_wake, ext_irq} = '0;
    endtask

    // one cycle: inputs are set at a negedge, model advances, compare at next negedge
    task automatic cycle();
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        clear_in();
        m_mode = 0; m_pend = 0; m_cnt = 0;
        #1;
        check("R1", 32'(mode_o), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare_all();
        check("R1", 32'({cpu_clk_en, periph_clk_en, rtc_clk_en, mem_pd, reg_lp}),
              32'({1'b1, {NP{1'b1}}, 1'b1, 2'b00}));
    endtask

    initial begin
        #(4 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int wlen;
        void'($urandom(32'd1234));
        periph_keep = 8'hA5;
        do_reset();

        // R2 priority: halt beats everything
        req_halt = 1; req_ahalt = 1; req_ls_enter = 1; req_wfi = 1;
        cycle(); clear_in();
        check("R2", 32'(mode_o), 32'd5);
        // R7 rtc and irq ignored in halt
        rtc_wake = 1; irq = 1; evt = 1; cycle(); clear_in();
        check("R7", 32'(mode_o), 32'd5);
        // R8 slow wake length
        ext_irq = 1; fast_wake = 0; cycle(); clear_in();
        wlen = 0;
        while (mode_o == 3'd6 && wlen < 100) begin wlen++; cycle(); end
        check("R8", 32'(wlen), 32'(SLOW));
        // R2 active-halt beats low-speed; R6 fast wake
        req_ahalt = 1; req_ls_enter = 1; cycle(); clear_in();
        check("R2", 32'(mode_o), 32'd4);
        irq = 1; evt = 1; cycle(); clear_in();
        check("R6", 32'(mode_o), 32'd4);
        rtc_wake = 1; fast_wake = 1; cycle(); clear_in(); fast_wake = 0;
        wlen = 0;
        while (mode_o == 3'd6 && wlen < 100) begin wlen++; cycle(); end
        check("R8", 32'(wlen), 32'(FAST));
        // R4 exit held while oscillator not ready, irq ignored
        req_ls_enter = 1; req_wfi = 1; cycle(); clear_in();
        check("R2", 32'(mode_o), 32'd2);
        hs_ready = 0; req_ls_exit = 1; cycle(); clear_in();
        irq = 1; req_wfe = 1; cycle(); clear_in();
        check("R4", 32'(mode_o), 32'd2);
        hs_ready = 1; cycle();
        check("R4", 32'(mode_o), 32'd0);
        hs_ready = 0;
        // R5 low-speed wait returns to low-speed run
        req_ls_enter = 1; cycle(); clear_in();
        req_wfe = 1; cycle(); clear_in();
        check("R5", 32'(mode_o), 32'd3);
        irq = 1; cycle(); clear_in();
        check("R5", 32'(mode_o), 32'd3);
        evt = 1; cycle(); clear_in();
        check("R5", 32'(mode_o), 32'd2);
        // R1 reset with a pending exit clears it
        req_ls_exit = 1; cycle(); clear_in();
        do_reset();
        req_ls_enter = 1; cycle(); clear_in();
        hs_ready = 1; cycle(); hs_ready = 0;
        check("R1", 32'(mode_o), 32'd2);
        // R3 wait and wake
        do_reset();
        req_wfe = 1; cycle(); clear_in();
        check("R3", 32'(mode_o), 32'd1);
        irq = 1; cycle(); clear_in();
        check("R3", 32'(mode_o), 32'd0);

        // random phase
        for (int n = 0; n < 20000; n++) begin
            req_wfi      = ($urandom % 12) == 0;
            req_wfe      = ($urandom % 10) == 0;
            req_ls_enter = ($urandom % 14) == 0;
            req_ls_exit  = ($urandom % 8) == 0;
            req_halt     = ($urandom % 25) == 0;
            req_ahalt    = ($urandom % 25) == 0;
            irq          = ($urandom % 6) == 0;
            evt          = ($urandom % 7) == 0;
            rtc_wake     = ($urandom % 9) == 0;
            ext_irq      = ($urandom % 15) == 0;
            fast_wake    = $urandom % 2;
            hs_ready     = ($urandom % 3) == 0;
            periph_keep  = NP'($urandom);
            if (($urandom % 3000) == 0) begin
                do_reset();
            end else begin
                cycle();
            end
        end
        clear_in();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule